// File: doc/BRIEF.md
# Observable Stream Shift Chain

This block is a line of registered valid/ready stages. Items enter at a push stream, pass through every stage in turn and leave at a pop stream. Each stage is a forward-registered copy of the stage before it, so an item needs one clock per stage to cross an empty chain. Items always leave in the order they entered.

The occupancy flag and payload of every stage are also driven out as side outputs. Logic next to the chain can watch the items in flight without taking them out. A synchronous clear input empties every stage on one clock edge. While clear is high, the chain takes nothing in and offers nothing out.

A stage can take a new item when it is empty, or when its own item moves on in the same cycle. A full chain therefore streams one item per cycle while the pop side is ready. Empty stages between items close up even when the pop side stalls.

Top module: `obs_shift_chain`

## Requirements
- R1: After reset every stage view is empty (`view_valid` all zero), `out_valid` is 0 and `in_ready` is 1.
- R2: An item accepted into an empty chain, with `out_ready` high, shows on `out_valid`/`out_data` after exactly DEPTH rising edges, counting the edge that accepted it. It is not visible before that.
- R3: Items leave in the order they were accepted, with their payloads unchanged.
- R4: With all stages full and `out_ready` high, `in_ready` is 1. One item leaves and one enters on every clock.
- R5: With all stages full and `out_ready` low, `in_ready` is 0 and no stage changes its flag or payload.
- R6: A stage that is empty takes the item from the stage behind it even when the stages ahead are stalled. With `out_ready` low, an empty chain accepts exactly DEPTH items and then refuses the next one.
- R7: `view_valid[i]` and `view_data[i*DATA_W +: DATA_W]` give the occupancy and payload of stage i. Stage 0 is next to the push side and stage DEPTH-1 drives the pop side. Watching these outputs never removes an item.
- R8: When `flush` is high at a rising edge, every stage is empty after that edge. While `flush` is high, `in_ready` and `out_valid` are 0, and an item offered on the push side is not taken.
- R9: Once `out_valid` is high, it stays high with `out_data` unchanged until a cycle with `out_ready` high, unless `flush` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous clear of all stages, active high; tie low when unused |
| in_valid | input | 1 | Push side: an item is offered |
| in_ready | output | 1 | Push side: the chain takes the offered item this cycle |
| in_data | input | DATA_W | Push side payload |
| out_valid | output | 1 | Pop side: the last stage holds an item |
| out_ready | input | 1 | Pop side: the consumer takes the item this cycle |
| out_data | output | DATA_W | Pop side payload |
| view_valid | output | DEPTH | Occupancy flag of each stage, bit i for stage i |
| view_data | output | DEPTH*DATA_W | Payload of each stage, stage i in bits i*DATA_W upward |

## Verification
The hardest case to reach is a partly filled chain with gaps between items while the pop side alternates between stalled and ready. In that case a stage behind a gap must move forward while a stage further ahead holds. The stimulus drives push-valid and pop-ready with two interleaved arithmetic patterns of different periods, so that the gaps and stalls fall in many relative positions. A flush is dropped into some runs while the chain is part full. Every payload comes from its acceptance index, so order, loss and duplication show directly at the pop side and in the stage views.

// File: rtl/obs_chain_pkg.sv
package obs_chain_pkg;
  // Bit offset of one stage's payload inside the packed view bus.
  function automatic int unsigned view_lo(input int unsigned stage, input int unsigned width);
    return stage * width;
  endfunction
endpackage

// File: rtl/chain_stage.sv
module chain_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              up_valid,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_ready,
  input  logic              dn_ready,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  // Take a new item when empty or when the held item leaves this cycle.
  assign up_ready = (~full_q | dn_ready) & ~flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end

  assign st_valid = full_q;
  assign st_data  = data_q;

  // A stalled stage keeps its item intact.
  assert_stage_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (full_q && !dn_ready && !flush) |=> (full_q && $stable(data_q)));
endmodule

// File: rtl/obs_shift_chain.sv
module obs_shift_chain #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DATA_W-1:0]       in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic [DEPTH-1:0]        view_valid,
  output logic [DEPTH*DATA_W-1:0] view_data
);
  import obs_chain_pkg::*;

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0]  stg_valid;
  logic [DEPTH-1:0]  stg_ready;
  logic [DATA_W-1:0] stg_data [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic              feed_valid;
    logic [DATA_W-1:0] feed_data;
    logic              take_ready;

    if (g == 0) begin : g_head
      assign feed_valid = in_valid;
      assign feed_data  = in_data;
    end else begin : g_body
      assign feed_valid = stg_valid[g-1];
      assign feed_data  = stg_data[g-1];
    end

    if (g == LAST) begin : g_tail
      assign take_ready = out_ready;
    end else begin : g_mid
      assign take_ready = stg_ready[g+1];
    end

    chain_stage #(.DATA_W(DATA_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .up_valid (feed_valid),
      .up_data  (feed_data),
      .up_ready (stg_ready[g]),
      .dn_ready (take_ready),
      .st_valid (stg_valid[g]),
      .st_data  (stg_data[g])
    );

    assign view_data[view_lo(g, DATA_W) +: DATA_W] = stg_data[g];
  end

  assign view_valid = stg_valid;
  assign in_ready   = stg_ready[0];
  assign out_valid  = stg_valid[LAST] & ~flush;
  assign out_data   = stg_data[LAST];

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (view_valid == '0));

  assert_flush_gates_R8: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!in_ready && !out_valid));

  assert_full_stall_R5: assert property (@(posedge clk) disable iff (rst)
    ((&view_valid) && !out_ready) |-> !in_ready);

  assert_pop_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (flush || (out_valid && $stable(out_data))));
endmodule

// File: tb/obs_shift_chain_tb.sv
module obs_shift_chain_tb;
  localparam int W = 8;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst, flush, in_valid, out_ready;
  logic [W-1:0] in_data;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;
  logic [D-1:0] view_valid;
  logic [D*W-1:0] view_data;

  int checks = 0;
  int fails  = 0;
  int push_n = 0;
  int pop_n  = 0;
  bit done   = 0;

  // bench model of stage contents
  bit         mv [D];
  logic [W-1:0] md [D];

  always #10 clk = ~clk;

  obs_shift_chain #(.DATA_W(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .view_valid(view_valid), .view_data(view_data)
  );

  function automatic logic [W-1:0] item(input int n);
    return W'((n * 37 + 5) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, check, then apply the model at the edge.
  task automatic step(input bit iv, input bit ord, input bit fl);
    bit rdy [D];
    bit nv [D];
    logic [W-1:0] nd [D];
    @(negedge clk);
    in_valid = iv; out_ready = ord; flush = fl; in_data = item(push_n);
    #1;
    for (int i = D - 1; i >= 0; i--) begin
      bit dn;
      dn = (i == D - 1) ? ord : rdy[i+1];
      rdy[i] = (!mv[i] || dn) && !fl;
    end
    chk("R8/R6 in_ready", in_ready, rdy[0]);
    chk("R8/R2 out_valid", out_valid, mv[D-1] && !fl);
    for (int i = 0; i < D; i++) begin
      chk("R7 view_valid", view_valid[i], mv[i]);
      if (mv[i]) chk("R7 view_data", view_data[i*W +: W], md[i]);
    end
    if (D == 3 && mv[0] && mv[1] && mv[2] && !fl)
      chk(ord ? "R4 full streams" : "R5 full stalls", in_ready, ord);
    if (out_valid && ord) begin
      chk("R3 order", out_data, item(pop_n));
      pop_n++;
    end
    @(posedge clk);
    for (int i = 0; i < D; i++) begin nv[i] = mv[i]; nd[i] = md[i]; end
    if (fl) begin
      for (int i = 0; i < D; i++) nv[i] = 0;
      pop_n = push_n;
    end else begin
      for (int i = 0; i < D; i++)
        if (rdy[i]) begin
          nv[i] = (i == 0) ? iv : mv[i-1];
          if (nv[i]) nd[i] = (i == 0) ? item(push_n) : md[i-1];
        end
      if (iv && rdy[0]) push_n++;
    end
    for (int i = 0; i < D; i++) begin mv[i] = nv[i]; md[i] = nd[i]; end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; flush = 0; in_valid = 0; out_ready = 0; in_data = '0;
    for (int i = 0; i < D; i++) begin mv[i] = 0; md[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    chk("R1 view_valid", view_valid, '0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);

    // R2: latency through an empty chain is D edges
    step(1, 1, 0);
    for (int k = 1; k < D; k++) begin
      #1 chk("R2 not early", out_valid, 0);
      step(0, 1, 0);
    end
    #1 chk("R2 arrives", out_valid, 1);
    chk("R2 payload", out_data, item(0));
    step(0, 1, 0);

    // R6/R5: fill with pop stalled, then refuse one more
    for (int k = 0; k < D + 2; k++) step(1, 0, 0);
    chk("R6 fill count", push_n - pop_n, D);
    #1 chk("R5 refused", in_ready, 0);
    // R9: stalled pop item stays put
    chk("R9 stable", out_data, item(pop_n));
    // R4: stream with pop ready
    for (int k = 0; k < 6; k++) step(1, 1, 0);
    // R8: flush while full, push offered but ignored
    step(1, 1, 1);
    #1 chk("R8 flushed", view_valid, '0);
    for (int k = 0; k < D + 1; k++) step(0, 1, 0);

    // near-exhaustive interleaved patterns
    for (int run = 0; run < 64; run++)
      for (int c = 0; c < 12; c++)
        step(((c * 7 + run) % 3) != 0, ((c * 3 + run) % 4) != 0,
             (run % 16 == 15) && (c == 5));
    // drain and compare totals
    for (int k = 0; k < D + 2; k++) step(0, 1, 0);
    chk("R3 nothing lost", pop_n, push_n);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule